// File: doc/BRIEF.md
# Four-Channel Compare System Timer

This block is a memory-mapped timer built around a free-running counter that advances by one on every cycle where a tick-enable input is high. The tick is normally a one-microsecond strobe made elsewhere. Several compare channels each hold a value. A channel fires when its value equals the low part of the counter. When it fires, it latches a sticky flag in a shared status word and raises that channel's own interrupt line.

Software arms a channel by writing a target value into its compare register. Because only the low part of the counter takes part in the match, the distance to the match is taken modulo the compare width. Software clears a flag by writing a one to its bit in the status word, which also drops that channel's interrupt. The counter width, the compare width, the channel count, the bus data width and the address width are all parameters. The defaults give a 64-bit counter, 32-bit compares, four channels and a 32-byte window.

Register word map (byte offset): 0x00 status, 0x04 counter bits [31:0], 0x08 counter bits [63:32], then compare channel N at 0x0C + 4·N. The bottom two address bits are ignored.

Top module: `stmr_top`

## Requirements
- R1: After reset the counter, every compare register and every status bit read as 0, and all interrupt outputs are low.
- R2: The counter increases by exactly 1 at each clock edge where `tick_en` is high and holds otherwise. It wraps from all-ones to 0.
- R3: A compare register keeps only its low CMP_W bits. Channel N matches when the counter's new low CMP_W bits equal its compare value, and the upper counter bits play no part. A match sets status bit N at the same edge where the counter takes that value.
- R4: A status bit is sticky. It stays set until acknowledged. A match is detected only on an edge where the counter advances, so a counter that holds on the compare value does not set the bit again after an acknowledge.
- R5: A write to offset 0x00 clears exactly the status bits whose data bit is 1 and leaves bits written as 0 unchanged.
- R6: When a match on channel N and an acknowledge of bit N fall on the same edge, the bit ends up set.
- R7: A write to offset 0x0C + 4·N stores the compare value for channel N and reads back from that offset. The new value is used from the next edge on, and the write leaves the status bit of that channel as it was.
- R8: The two counter words are read-only, and writes to them have no effect on the counter.
- R9: Reads of offsets with no register return 0, and writes to them change nothing.
- R10: Interrupt output N is high exactly when status bit N is set. Each channel has its own line.
- R11: A compare value below the current low counter bits fires only after the low bits wrap, that is, 2^CMP_W minus the distance ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance strobe |
| addr | input | AW (5) | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for `addr`, combinational |
| irq | output | NCH (4) | Per-channel interrupt lines |

## Verification
The bench builds the timer with a 16-bit counter and 8-bit compare registers, keeping four channels and the 32-bit bus. With these values, the low-word wrap behind a late compare and the full counter rollover can both be reached within a short run. The narrow compare width also makes a compare match repeat every 256 ticks while the upper counter bits differ, which shows that those bits are left out of the match. The readout of the high counter word then shows the zero extension of a counter narrower than the bus.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
   // word indices inside the register window
   localparam int unsigned W_STATUS = 0;
   localparam int unsigned W_CNT_LO = 1;
   localparam int unsigned W_CNT_HI = 2;
   localparam int unsigned W_CMP0   = 3;
   localparam int unsigned N_FIXED  = 3;
endpackage

// File: rtl/stmr_counter.sv
module stmr_counter #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned CMP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CMP_W-1:0] lo_next,
   output logic             lo_step
);
   localparam int unsigned HI_W = (CNT_W > CMP_W) ? CNT_W - CMP_W : 1;

   logic [CMP_W-1:0] lo_q;
   logic             lo_carry;

   assign {lo_carry, lo_next} = {1'b0, lo_q} + {{CMP_W{1'b0}}, 1'b1};
   assign lo_step = tick_en;

   always_ff @(posedge clk) begin
      if (!rst_n)       lo_q <= '0;
      else if (tick_en) lo_q <= lo_next;
   end

   generate
      if (CNT_W == CMP_W) begin : g_flat
         assign cnt_q = lo_q;
      end else begin : g_split
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                   hi_q <= '0;
            else if (tick_en && lo_carry) hi_q <= hi_q + 1'b1;
         end
         assign cnt_q = {hi_q, lo_q};
      end
   endgenerate

   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && tick_en) |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !tick_en) |=> $stable(cnt_q));
endmodule

// File: rtl/stmr_channel.sv
module stmr_channel #(
   parameter int unsigned CMP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_we,
   input  logic [CMP_W-1:0] cmp_wdata,
   input  logic             ack,
   input  logic             lo_step,
   input  logic [CMP_W-1:0] lo_next,
   output logic [CMP_W-1:0] cmp_q,
   output logic             flag_q
);
   logic hit;

   assign hit = lo_step && (lo_next == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (cmp_we) cmp_q <= cmp_wdata;
         flag_q <= (flag_q && !ack) || hit;
      end
   end

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && hit) |=> flag_q);
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && flag_q && !ack) |=> flag_q);
   p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && ack && !lo_step) |=> !flag_q);
   p_cmp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !cmp_we) |=> $stable(cmp_q));
endmodule

// File: rtl/stmr_rdmux.sv
module stmr_rdmux
   import stmr_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned CNT_W = 64,
   parameter int unsigned CMP_W = 32,
   parameter int unsigned NCH   = 4,
   parameter int unsigned WW    = 3
) (
   input  logic [WW-1:0]        word,
   input  logic [NCH-1:0]       status,
   input  logic [CNT_W-1:0]     cnt,
   input  logic [NCH*CMP_W-1:0] cmp_flat,
   output logic [DW-1:0]        rdata
);
   logic [2*DW-1:0] cnt_wide;
   logic [DW-1:0]   cmp_word [NCH];
   logic [DW-1:0]   stat_word;

   always_comb begin
      cnt_wide = '0;
      cnt_wide[CNT_W-1:0] = cnt;
      stat_word = '0;
      stat_word[NCH-1:0] = status;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ext
      always_comb begin
         cmp_word[i] = '0;
         cmp_word[i][CMP_W-1:0] = cmp_flat[i*CMP_W +: CMP_W];
      end
   end

   always_comb begin
      rdata = '0;
      if (word == WW'(W_STATUS))      rdata = stat_word;
      else if (word == WW'(W_CNT_LO)) rdata = cnt_wide[DW-1:0];
      else if (word == WW'(W_CNT_HI)) rdata = cnt_wide[2*DW-1:DW];
      for (int i = 0; i < NCH; i++) begin
         if (word == WW'(W_CMP0 + i)) rdata = cmp_word[i];
      end
   end
endmodule

// File: rtl/stmr_top.sv
module stmr_top
   import stmr_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned AW    = 5,
   parameter int unsigned CNT_W = 64,
   parameter int unsigned CMP_W = 32,
   parameter int unsigned NCH   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [NCH-1:0] irq
);
   localparam int unsigned WW     = AW - 2;
   localparam int unsigned NWORDS = 1 << WW;

   generate
      if (AW < 3)                begin : g_bad_aw  $error("address too narrow"); end
      if (N_FIXED + NCH > NWORDS) begin : g_bad_nch $error("channels exceed window"); end
      if (CMP_W > DW || CMP_W > CNT_W) begin : g_bad_cmp $error("compare width"); end
      if (CNT_W > 2 * DW)        begin : g_bad_cnt $error("counter wider than two words"); end
      if (NCH > DW)              begin : g_bad_st  $error("status wider than bus"); end
   endgenerate

   logic [WW-1:0]        word;
   logic [CNT_W-1:0]     cnt;
   logic [CMP_W-1:0]     lo_next;
   logic                 lo_step;
   logic [NCH-1:0]       status;
   logic [NCH*CMP_W-1:0] cmp_flat;
   logic                 st_we;

   assign word  = addr[AW-1:2];
   assign st_we = wr_en && (word == WW'(W_STATUS));

   stmr_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .cnt_q(cnt), .lo_next(lo_next), .lo_step(lo_step)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic cmp_we;
      assign cmp_we = wr_en && (word == WW'(W_CMP0 + i));
      stmr_channel #(.CMP_W(CMP_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .cmp_we(cmp_we), .cmp_wdata(wdata[CMP_W-1:0]),
         .ack(st_we && wdata[i]),
         .lo_step(lo_step), .lo_next(lo_next),
         .cmp_q(cmp_flat[i*CMP_W +: CMP_W]), .flag_q(status[i])
      );
   end

   stmr_rdmux #(.DW(DW), .CNT_W(CNT_W), .CMP_W(CMP_W), .NCH(NCH), .WW(WW)) u_rd (
      .word(word), .status(status), .cnt(cnt), .cmp_flat(cmp_flat), .rdata(rdata)
   );

   assign irq = status;

   p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && (word >= WW'(N_FIXED + NCH))) |-> (rdata == '0));
   p_irq_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !tick_en && !st_we) |=> (irq == $past(irq)));
endmodule

// File: tb/stmr_top_test.sv
module stmr_top_test;
   localparam int CLK_P = 10;
   localparam int DW = 32, AW = 5, CNT_W = 16, CMP_W = 8, NCH = 4;
   localparam logic [63:0] CMASK = (64'd1 << CNT_W) - 1;
   localparam logic [63:0] LMASK = (64'd1 << CMP_W) - 1;

   logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NCH-1:0] irq;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [63:0]    m_cnt = 0;
   logic [63:0]    m_cmp [NCH];
   logic [NCH-1:0] m_st = '0;

   always #(CLK_P/2) clk = ~clk;

   stmr_top #(.DW(DW), .AW(AW), .CNT_W(CNT_W), .CMP_W(CMP_W), .NCH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
      int w = int'(a[AW-1:2]);
      if (w == 0) return DW'(m_st);
      if (w == 1) return m_cnt[31:0];
      if (w == 2) return m_cnt[63:32];
      if (w >= 3 && w < 3 + NCH) return m_cmp[w-3][31:0];
      return '0;
   endfunction

   // one clock: drive at falling edge, update the model at the rising edge
   task automatic cyc(bit t, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
      logic [NCH-1:0] hit, ack;
      int wi;
      @(negedge clk);
      tick_en = t; wr_en = w; addr = a; wdata = d;
      @(posedge clk);
      if (rst_n) begin
         hit = '0;
         for (int i = 0; i < NCH; i++)
            hit[i] = t && ((((m_cnt + 1) & LMASK)) == m_cmp[i]);
         ack = (w && a[AW-1:2] == 0) ? d[NCH-1:0] : '0;
         m_st = (m_st & ~ack) | hit;
         wi = int'(a[AW-1:2]);
         if (w && wi >= 3 && wi < 3 + NCH) m_cmp[wi-3] = {32'd0, d} & LMASK;
         if (t) m_cnt = (m_cnt + 1) & CMASK;
      end
      #1;
      tick_en = 0; wr_en = 0;
   endtask

   task automatic chk(logic [AW-1:0] a, string req);
      logic [DW-1:0] e;
      addr = a;
      #1;
      e = exp_read(a);
      checks++;
      if (rdata !== e) begin
         fails++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, e);
      end
      checks++;
      if (irq !== m_st) begin
         fails++;
         $display("FAIL R10 irq actual=%b expected=%b", irq, m_st);
      end
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h5EED));
      for (int i = 0; i < NCH; i++) m_cmp[i] = 0;
      cyc(1, 1, 5'h0C, 32'h55);   // activity during reset is ignored
      cyc(0, 0, 0, 0);
      @(negedge clk); rst_n = 1;
      // R1 reset state
      for (int a = 0; a < 32; a += 4) chk(AW'(a), "R1");

      // R2 count and hold
      ticks(5); chk(5'h04, "R2");
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
      chk(5'h04, "R2");

      // R7 write/readback, R3 match timing
      cyc(0, 1, 5'h0C, 32'h0000_0108);    // only low 8 bits kept: 0x08
      chk(5'h0C, "R7");
      chk(5'h00, "R7");
      ticks(2); chk(5'h00, "R3");         // counter 7, no hit yet
      ticks(1); chk(5'h00, "R3");         // counter 8, bit0 set
      chk(5'h04, "R3");

      // R4 no refire while holding on the compare value
      cyc(0, 1, 5'h00, 32'h1); chk(5'h00, "R5");
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
      chk(5'h00, "R4");

      // set several channels, partial acknowledge
      cyc(0, 1, 5'h10, 32'd10);
      cyc(0, 1, 5'h14, 32'd10);
      cyc(0, 1, 5'h18, 32'd10);
      cyc(0, 1, 5'h0C, 32'd10);
      ticks(2); chk(5'h00, "R3");
      cyc(0, 1, 5'h0C, 32'd50); chk(5'h00, "R7");   // rewrite keeps bit
      cyc(0, 1, 5'h00, 32'h5);  chk(5'h00, "R5");
      ticks(3); chk(5'h00, "R4");

      // R6 set wins over simultaneous acknowledge
      cyc(0, 1, 5'h10, 32'(((m_cnt + 1) & LMASK)));
      cyc(1, 1, 5'h00, 32'h2); chk(5'h00, "R6");
      // R7 new compare value only used from the next edge
      cyc(1, 1, 5'h14, 32'(((m_cnt + 1) & LMASK))); chk(5'h00, "R7");

      // R8 read-only counter words
      cyc(0, 1, 5'h04, 32'hFFFF_FFFF); chk(5'h04, "R8");
      cyc(0, 1, 5'h08, 32'hFFFF_FFFF); chk(5'h08, "R8");
      // R9 unmapped
      cyc(0, 1, 5'h1C, 32'hFFFF_FFFF); chk(5'h1C, "R9");
      for (int a = 0; a < 28; a += 4) chk(AW'(a), "R9");

      // R11 compare behind the counter fires after low wrap
      cyc(0, 1, 5'h00, 32'hF);
      v = 8'(m_cnt) - 8'd2;
      cyc(0, 1, 5'h18, 32'(v));
      ticks(253); chk(5'h00, "R11");
      ticks(1);   chk(5'h00, "R11");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int r = int'($urandom_range(0, 9));
         logic [AW-1:0] a = AW'($urandom_range(0, 7) * 4);
         logic [DW-1:0] d = (a == 0) ? DW'($urandom_range(0, 15)) : DW'($urandom_range(0, 511));
         cyc(r < 7, r >= 6, a, d);
         chk(AW'($urandom_range(0, 7) * 4), "R3");
      end

      // R2 full wrap of the counter
      while (m_cnt != CMASK) cyc(1, 0, 0, 0);
      chk(5'h04, "R2");
      ticks(1);
      chk(5'h04, "R2"); chk(5'h08, "R2");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule